// File: doc/BRIEF.md
# Byte-Wide Arithmetic/Logic Unit with Compare Flags

This block is the arithmetic and logic stage of a small 8-bit processor. Each cycle it can accept one operation: an operation code and two operand values read from the register file. It computes an 8-bit result that is meant to be written back to the first operand's register. It also keeps a 3-bit condition register that later conditional branches inspect.

The supported operations are add, multiply, bitwise AND, OR and XOR, and an unsigned compare. Compare produces no write-back. It only replaces the condition register with a one-hot code that says whether the first operand was less than, greater than or equal to the second. All outputs are registered and appear one clock after the operation is presented. Add and multiply keep only the low eight bits of their results.

Top module: `byte_alu`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `res_valid`, `res_we`, `res_data` and `flags` are all zero.
- R2: Opcode 0xA0 presented with `op_valid` gives `res_data` = (`opnd_a` + `opnd_b`) mod 256 with `res_we` = 1, one clock later.
- R3: Opcode 0xA2 gives the low eight bits of `opnd_a` × `opnd_b` with `res_we` = 1, one clock later.
- R4: Opcodes 0xA8, 0xAA and 0xAB give the bitwise AND, OR and XOR of the operands respectively, with `res_we` = 1, one clock later.
- R5: Opcode 0xA7 keeps `res_we` at 0 and `res_data` unchanged, and loads `flags` with 3'b100 if `opnd_a` < `opnd_b`, 3'b010 if greater, 3'b001 if equal. The compare is unsigned, and all three bits are replaced on every compare.
- R6: `flags` changes only on a cycle that presents opcode 0xA7 with `op_valid` high. Other operations, idle cycles and 0xA7 without `op_valid` leave it unchanged.
- R7: `res_valid` equals `op_valid` delayed by one clock. When no operation was presented, `res_we` is 0 and `res_data` holds its value.
- R8: An opcode outside the six listed gives `res_valid` = 1 and `res_we` = 0, and leaves `res_data` and `flags` unchanged.
- R9: `flags` is never anything other than zero or one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 8 | Operation code |
| opnd_a | input | W (8) | First operand, destination register value |
| opnd_b | input | W (8) | Second operand |
| res_valid | output | 1 | Registered: an operation was accepted last cycle |
| res_we | output | 1 | Registered: write `res_data` back to the first register |
| res_data | output | W (8) | Registered result |
| flags | output | 3 | Condition register: bit 2 less, bit 1 greater, bit 0 equal |

## Verification
The properties assume that `rst` is high from time zero and that `op_valid`, `op_code` and the operands carry known values at every sampling edge after reset. Their `$past` references therefore never see undriven inputs. The stimulus changes inputs only at a fixed offset after each rising edge, and it drives `op_valid` low together with defined operand values whenever it is idle. Operand values include the all-zero and all-ones extremes, so that wrap-around and unsigned ordering are exercised within those assumptions.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int OPC_W  = 8;
  localparam int FLAG_W = 3;

  localparam logic [OPC_W-1:0] OPC_ADD = 8'hA0;
  localparam logic [OPC_W-1:0] OPC_MUL = 8'hA2;
  localparam logic [OPC_W-1:0] OPC_CMP = 8'hA7;
  localparam logic [OPC_W-1:0] OPC_AND = 8'hA8;
  localparam logic [OPC_W-1:0] OPC_OR  = 8'hAA;
  localparam logic [OPC_W-1:0] OPC_XOR = 8'hAB;

  localparam logic [FLAG_W-1:0] FLG_LT = 3'b100;
  localparam logic [FLAG_W-1:0] FLG_GT = 3'b010;
  localparam logic [FLAG_W-1:0] FLG_EQ = 3'b001;
endpackage

// File: rtl/alu_lowmul.sv
// Low half of an unsigned product, built from shifted partial products.
module alu_lowmul #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod
);
  logic [W-1:0] pp [W];

  for (genvar i = 0; i < W; i++) begin : g_pp
    assign pp[i] = b[i] ? (a << i) : '0;
  end

  always_comb begin
    logic [W-1:0] acc;
    acc = '0;
    for (int k = 0; k < W; k++) acc = acc + pp[k];
    prod = acc;
  end
endmodule

// File: rtl/alu_compare.sv
// Unsigned magnitude compare producing a one-hot condition code.
module alu_compare #(
  parameter int W = 8
) (
  input  logic [W-1:0]                        a,
  input  logic [W-1:0]                        b,
  output logic [byte_alu_pkg::FLAG_W-1:0]     code
);
  import byte_alu_pkg::*;

  always_comb begin
    if (a < b)      code = FLG_LT;
    else if (a > b) code = FLG_GT;
    else            code = FLG_EQ;
  end
endmodule

// File: rtl/alu_opsel.sv
// Opcode decode and result selection.
module alu_opsel #(
  parameter int W = 8
) (
  input  logic [byte_alu_pkg::OPC_W-1:0] op_code,
  input  logic [W-1:0]                   a,
  input  logic [W-1:0]                   b,
  input  logic [W-1:0]                   prod,
  output logic [W-1:0]                   result,
  output logic                           wr_ok,
  output logic                           is_cmp
);
  import byte_alu_pkg::*;

  always_comb begin
    result = '0;
    wr_ok  = 1'b0;
    is_cmp = 1'b0;
    case (op_code)
      OPC_ADD: begin result = a + b; wr_ok = 1'b1; end
      OPC_MUL: begin result = prod;  wr_ok = 1'b1; end
      OPC_AND: begin result = a & b; wr_ok = 1'b1; end
      OPC_OR:  begin result = a | b; wr_ok = 1'b1; end
      OPC_XOR: begin result = a ^ b; wr_ok = 1'b1; end
      OPC_CMP: is_cmp = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu #(
  parameter int W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            op_valid,
  input  logic [byte_alu_pkg::OPC_W-1:0]  op_code,
  input  logic [W-1:0]                    opnd_a,
  input  logic [W-1:0]                    opnd_b,
  output logic                            res_valid,
  output logic                            res_we,
  output logic [W-1:0]                    res_data,
  output logic [byte_alu_pkg::FLAG_W-1:0] flags
);
  import byte_alu_pkg::*;

  logic [W-1:0]      prod;
  logic [W-1:0]      result;
  logic              wr_ok;
  logic              is_cmp;
  logic [FLAG_W-1:0] cmp_code;

  alu_lowmul #(.W(W)) u_mul (.a(opnd_a), .b(opnd_b), .prod(prod));

  alu_compare #(.W(W)) u_cmp (.a(opnd_a), .b(opnd_b), .code(cmp_code));

  alu_opsel #(.W(W)) u_sel (
    .op_code(op_code), .a(opnd_a), .b(opnd_b), .prod(prod),
    .result(result), .wr_ok(wr_ok), .is_cmp(is_cmp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_we    <= 1'b0;
      res_data  <= '0;
      flags     <= '0;
    end else begin
      res_valid <= op_valid;
      res_we    <= op_valid & wr_ok;
      if (op_valid && wr_ok)  res_data <= result;
      if (op_valid && is_cmp) flags    <= cmp_code;
    end
  end
endmodule

// File: rtl/byte_alu_checker.sv
module byte_alu_checker #(
  parameter int W = 8
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            op_valid,
  input logic [byte_alu_pkg::OPC_W-1:0]  op_code,
  input logic [W-1:0]                    opnd_a,
  input logic [W-1:0]                    opnd_b,
  input logic                            res_valid,
  input logic                            res_we,
  input logic [W-1:0]                    res_data,
  input logic [byte_alu_pkg::FLAG_W-1:0] flags
);
  import byte_alu_pkg::*;

  logic [W-1:0] sum_chk;
  logic [W-1:0] prod_chk;
  logic         known_op;
  assign sum_chk  = opnd_a + opnd_b;
  assign prod_chk = opnd_a * opnd_b;
  assign known_op = (op_code == OPC_ADD) || (op_code == OPC_MUL) ||
                    (op_code == OPC_CMP) || (op_code == OPC_AND) ||
                    (op_code == OPC_OR)  || (op_code == OPC_XOR);

  p_add_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_code == OPC_ADD |=> res_we && res_data == $past(sum_chk));

  p_mul_low_r3: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_code == OPC_MUL |=> res_we && res_data == $past(prod_chk));

  p_xor_r4: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_code == OPC_XOR |=> res_data == ($past(opnd_a) ^ $past(opnd_b)));

  p_cmp_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_code == OPC_CMP |=> !res_we && $stable(res_data));

  p_flags_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && op_code == OPC_CMP) |=> $stable(flags));

  p_valid_lat_r7: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !res_valid && !res_we && $stable(res_data));

  p_unknown_r8: assert property (@(posedge clk) disable iff (rst)
    op_valid && !known_op |=> res_valid && !res_we && $stable(res_data));

  p_flags_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flags));
endmodule

bind byte_alu byte_alu_checker #(.W(W)) u_chk (.*);

// File: tb/byte_alu_test.sv
module byte_alu_test;
  localparam int W = 8;

  typedef struct {
    logic         valid;
    logic         we;
    logic [W-1:0] data;
    logic [2:0]   flg;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic [7:0]   op_code = 8'h00;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic         res_valid, res_we;
  logic [W-1:0] res_data;
  logic [2:0]   flags;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  exp_t sb_q[$];
  logic [W-1:0] m_data  = '0;
  logic [2:0]   m_flags = '0;

  always #4 clk = ~clk;

  byte_alu #(.W(W)) uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid),
    .res_we(res_we), .res_data(res_data), .flags(flags)
  );

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: one pushed item per driven cycle.
  task automatic drive(bit v, logic [7:0] op, logic [W-1:0] a, logic [W-1:0] b, string req);
    exp_t e;
    @(posedge clk); #2;
    op_valid = v; op_code = op; opnd_a = a; opnd_b = b;
    e.valid = v; e.we = 1'b0; e.req = req;
    if (v) begin
      case (op)
        8'hA0: begin m_data = W'(int'(a) + int'(b));  e.we = 1'b1; end
        8'hA2: begin m_data = W'(int'(a) * int'(b));  e.we = 1'b1; end
        8'hA8: begin m_data = a & b; e.we = 1'b1; end
        8'hAA: begin m_data = a | b; e.we = 1'b1; end
        8'hAB: begin m_data = a ^ b; e.we = 1'b1; end
        8'hA7: m_flags = (int'(a) < int'(b)) ? 3'b100 :
                         (int'(a) > int'(b)) ? 3'b010 : 3'b001;
        default: ;
      endcase
    end
    e.data = m_data; e.flg = m_flags;
    sb_q.push_back(e);
  endtask

  // Monitor: pop the item due at this edge, sample after it settles.
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        #3;
        check(e.req, "res_valid", int'(res_valid), int'(e.valid));
        check(e.req, "res_we",    int'(res_we),    int'(e.we));
        check(e.req, "res_data",  int'(res_data),  int'(e.data));
        check(e.req, "flags",     int'(flags),     int'(e.flg));
      end
    end
  end

  initial begin
    #1600000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    check("R1", "res_valid", int'(res_valid), 0);
    check("R1", "res_we",    int'(res_we),    0);
    check("R1", "res_data",  int'(res_data),  0);
    check("R1", "flags",     int'(flags),     0);
    @(posedge clk); #2; rst = 1'b0;
    drive(0, 8'h00, 8'h00, 8'h00, "R1");         // idle, state still reset
    drive(1, 8'hA0, 8'd200, 8'd100, "R2");       // wraps to 44
    drive(1, 8'hA0, 8'd3, 8'd4, "R2");
    drive(1, 8'hA0, 8'hFF, 8'h01, "R2");
    drive(1, 8'hA2, 8'd16, 8'd16, "R3");         // 256 -> 0
    drive(1, 8'hA2, 8'd13, 8'd11, "R3");
    drive(1, 8'hA2, 8'hFF, 8'hFF, "R3");
    drive(1, 8'hA8, 8'hF0, 8'h3C, "R4");
    drive(1, 8'hAA, 8'hF0, 8'h3C, "R4");
    drive(1, 8'hAB, 8'hF0, 8'h3C, "R4");
    drive(1, 8'hA7, 8'd5, 8'd9, "R5");           // less
    drive(1, 8'hA7, 8'd200, 8'd7, "R5");         // greater, unsigned
    drive(1, 8'hA7, 8'h00, 8'hFF, "R5");         // less at extremes
    drive(1, 8'hA7, 8'h42, 8'h42, "R5");         // equal
    drive(1, 8'hA0, 8'd1, 8'd2, "R6");           // flags must hold
    drive(0, 8'hA7, 8'd1, 8'd9, "R6");           // compare code without valid
    drive(0, 8'hA0, 8'd9, 8'd9, "R7");
    drive(1, 8'hA1, 8'd7, 8'd7, "R8");           // unknown opcode
    drive(1, 8'h00, 8'd0, 8'd1, "R8");
    drive(1, 8'hA7, 8'd9, 8'd1, "R9");
    for (int i = 0; i < 300; i++) begin
      logic [7:0] ops [7] = '{8'hA0, 8'hA2, 8'hA7, 8'hA8, 8'hAA, 8'hAB, 8'h5E};
      drive(($urandom % 4) != 0, ops[$urandom % 7], W'($urandom), W'($urandom), "R2");
    end
    drive(0, 8'h00, 8'h00, 8'h00, "R7");
    @(posedge clk); @(posedge clk); #4;
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule